// File: doc/BRIEF.md
# Signature-Verify Mailbox Request Sequencer

This block is a hardware requester for a signature-verification service that sits behind a mailbox. A client hands over one request: a public key (X and Y coordinates) and a signature (R and S halves), each a 384-bit operand. The block takes the mailbox lock, confirms that the mailbox is waiting for a command, and writes the command code and the payload length. It then streams a checksum word followed by the 48 operand words, starts execution, polls for the result and releases the mailbox. It finishes with a one-cycle `done` pulse and exactly one outcome flag.

The request enters through a valid/ready handshake. `in_ready` is high only while the block is idle. A request is taken in the cycle where `in_valid` and `in_ready` are both high. The block keeps its own copy of the operands, so the client may change or drop them in the next cycle. A client that holds `in_valid` while `in_ready` is low is stalled, and nothing is lost. The mailbox side is a single-outstanding 32-bit register bus. A transfer holds `bus_req` with stable `bus_addr`, `bus_we` and `bus_wdata` until the mailbox returns `bus_ack`. Read data is taken in the `bus_ack` cycle.

The checksum is 0 minus the sum of all payload bytes, modulo 2^32. The bytes are the four bytes of the command code, least significant first, followed by the 192 operand bytes. The checksum is built one word per cycle while the lock is being taken. This keeps the adder to four bytes wide, and the mailbox never sees a payload word before the checksum is ready.

Top module: `sigver_mbox_seq`

## Requirements
- R1: `in_ready` is 1 exactly when the block is idle. A request is captured on `in_valid && in_ready`. Operand inputs that change after that cycle do not affect the words written.
- R2: The first bus access after a request is a read of the lock register at offset 0x00. It is repeated until a read returns 0, and no write is issued before that.
- R3: If a lock read returns nonzero once `LOCK_TIMEOUT` or more cycles have passed since the lock phase began, the block pulses `done` with `err_timeout=1` and issues no bus write.
- R4: After the lock is taken, status is read at offset 0x1C. If status bits [8:6] are not 1 (ready for command), the block pulses `done` with `err_phase=1` and issues no bus write.
- R5: On success the writes are, in order: 0x53494756 to offset 0x08, 196 to offset 0x0C, 49 words to offset 0x10, 1 to offset 0x18, and finally 0 to offset 0x18.
- R6: The first word written to 0x10 is 0 minus the sum of the bytes 0x56, 0x47, 0x49, 0x53, then X, Y, R and S bytes 0 to 47, where byte i of an operand is bits [8i+7:8i]. It is followed by the words of X, Y, R and S in that order, word k of an operand being bits [32k+31:32k].
- R7: After writing execute=1, the block reads 0x1C until bits [3:0] are nonzero (0 = busy). It then writes 0 to 0x18.
- R8: Result code 3 gives `res_fail=1`. Any other nonzero code gives `res_pass=1`. `done` lasts one cycle, and exactly one outcome flag is 1 with it.
- R9: Once raised, `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` stable until a cycle with `bus_ack`.
- R10: While idle the block makes no bus request. `in_ready` is low from the cycle after acceptance until the request finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request can be taken |
| key_x | input | 384 | Public key X coordinate |
| key_y | input | 384 | Public key Y coordinate |
| sig_r | input | 384 | Signature R half |
| sig_s | input | 384 | Signature S half |
| done | output | 1 | One-cycle completion pulse |
| res_pass | output | 1 | Verification reported success |
| res_fail | output | 1 | Verification reported failure (code 3) |
| err_timeout | output | 1 | Lock not obtained in time |
| err_phase | output | 1 | Mailbox not ready for a command |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | Mailbox register offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
All-zero operands leave only the command bytes in the checksum. All-ones operands drive the byte sum to its maximum, which exposes carry and width faults in the accumulator. Random operands, scrambled right after acceptance, separate a correct byte order and operand order from swapped ones and show whether the operands were really captured. Mailbox behaviours cover a lock held for several reads, a lock never freed, a wrong phase, long busy polling, and result codes 1, 2 and 3. Random acknowledge delays test the bus hold rule and the exact write order.

// File: rtl/sigv_pkg.sv
package sigv_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 8;
  localparam int NUM_OPER = 4;

  localparam logic [WORD_W-1:0] CMD_CODE = 32'h5349_4756;

  localparam logic [ADDR_W-1:0] OFS_LOCK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_LEN  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_EXEC = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STS  = 8'h1C;

  localparam logic [2:0] PH_READY = 3'd1;
  localparam logic [3:0] RC_BUSY  = 4'd0;
  localparam logic [3:0] RC_FAIL  = 4'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCK, S_PHASE, S_CMD, S_LEN, S_DATA, S_EXEC, S_POLL, S_REL
  } seq_st_t;
endpackage

// File: rtl/sigv_csum.sv
module sigv_csum
  import sigv_pkg::*;
#(
  parameter int WORDS = 49,
  parameter int IW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [WORD_W*WORDS-1:0] blob,
  output logic                    ok,
  output logic [WORD_W-1:0]       csum
);
  localparam int BPW = WORD_W / 8;
  localparam int SW = 8 + $clog2(BPW + 1);

  logic [IW-1:0] idx;
  logic          run;
  logic [WORD_W-1:0] cur;
  logic [7:0]    bytes [BPW];
  logic [SW-1:0] wsum;

  assign cur = blob[WORD_W*idx +: WORD_W];

  for (genvar b = 0; b < BPW; b++) begin : g_byte
    assign bytes[b] = cur[8*b +: 8];
  end

  always_comb begin
    wsum = '0;
    for (int b = 0; b < BPW; b++) wsum = wsum + SW'(bytes[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      run  <= 1'b0;
      ok   <= 1'b0;
      csum <= '0;
    end else if (start) begin
      idx  <= '0;
      run  <= 1'b1;
      ok   <= 1'b0;
      csum <= '0;
    end else if (run) begin
      csum <= csum - WORD_W'(wsum);
      if (idx == IW'(WORDS - 1)) begin
        run <= 1'b0;
        ok  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sigv_busm.sv
module sigv_busm
  import sigv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              busy,
  output logic              rsp,
  output logic [WORD_W-1:0] rsp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [WORD_W-1:0] bus_rdata
);
  assign bus_req = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rsp       <= 1'b0;
      rsp_data  <= '0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      rsp <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy      <= 1'b1;
          bus_we    <= go_we;
          bus_addr  <= go_addr;
          bus_wdata <= go_wdata;
        end
      end else if (bus_ack) begin
        busy     <= 1'b0;
        rsp      <= 1'b1;
        rsp_data <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/sigver_mbox_seq.sv
module sigver_mbox_seq
  import sigv_pkg::*;
#(
  parameter int OPER_BYTES   = 48,
  parameter int LOCK_TIMEOUT = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [OPER_BYTES*8-1:0] key_x,
  input  logic [OPER_BYTES*8-1:0] key_y,
  input  logic [OPER_BYTES*8-1:0] sig_r,
  input  logic [OPER_BYTES*8-1:0] sig_s,
  output logic                    done,
  output logic                    res_pass,
  output logic                    res_fail,
  output logic                    err_timeout,
  output logic                    err_phase,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [WORD_W-1:0]       bus_wdata,
  input  logic                    bus_ack,
  input  logic [WORD_W-1:0]       bus_rdata
);
  localparam int WPO       = OPER_BYTES / 4;
  localparam int PAY_WORDS = 1 + NUM_OPER * WPO;
  localparam int BLOB_W    = WORD_W * PAY_WORDS;
  localparam int PAY_BYTES = 4 + NUM_OPER * OPER_BYTES;
  localparam int IW        = $clog2(PAY_WORDS + 1);
  localparam int TW        = $clog2(LOCK_TIMEOUT + 1) + 1;

  seq_st_t           st;
  logic [BLOB_W-1:0] blob;
  logic [IW-1:0]     pidx;
  logic [TW-1:0]     tcnt;
  logic [3:0]        rc_q;
  logic              accept;

  logic              go, go_we;
  logic [ADDR_W-1:0] go_addr;
  logic [WORD_W-1:0] go_wdata;
  logic              bm_busy, bm_rsp;
  logic [WORD_W-1:0] bm_data;
  logic              cs_ok;
  logic [WORD_W-1:0] cs_val;
  logic              can_go;
  logic              unused_rd;

  assign in_ready  = (st == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign can_go    = !bm_busy && !bm_rsp;
  assign unused_rd = ^{bm_data[WORD_W-1:9], bm_data[5:4]};

  always_ff @(posedge clk) begin
    if (accept) blob <= {sig_s, sig_r, key_y, key_x, CMD_CODE};
  end

  sigv_csum #(.WORDS(PAY_WORDS), .IW(IW)) u_csum (
    .clk(clk), .rst_n(rst_n), .start(accept), .blob(blob),
    .ok(cs_ok), .csum(cs_val)
  );

  sigv_busm u_busm (
    .clk(clk), .rst_n(rst_n), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_wdata(go_wdata), .busy(bm_busy), .rsp(bm_rsp), .rsp_data(bm_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always_comb begin
    go       = 1'b0;
    go_we    = 1'b0;
    go_addr  = OFS_LOCK;
    go_wdata = '0;
    unique case (st)
      S_LOCK:  begin go = can_go; go_addr = OFS_LOCK; end
      S_PHASE: begin go = can_go; go_addr = OFS_STS; end
      S_CMD:   begin go = can_go; go_we = 1'b1; go_addr = OFS_CMD; go_wdata = CMD_CODE; end
      S_LEN:   begin go = can_go; go_we = 1'b1; go_addr = OFS_LEN; go_wdata = WORD_W'(PAY_BYTES); end
      S_DATA: begin
        go       = can_go && ((pidx != '0) || cs_ok);
        go_we    = 1'b1;
        go_addr  = OFS_DIN;
        go_wdata = (pidx == '0) ? cs_val : blob[WORD_W*pidx +: WORD_W];
      end
      S_EXEC:  begin go = can_go; go_we = 1'b1; go_addr = OFS_EXEC; go_wdata = 32'd1; end
      S_POLL:  begin go = can_go; go_addr = OFS_STS; end
      S_REL:   begin go = can_go; go_we = 1'b1; go_addr = OFS_EXEC; go_wdata = '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      pidx        <= '0;
      tcnt        <= '0;
      rc_q        <= RC_BUSY;
      done        <= 1'b0;
      res_pass    <= 1'b0;
      res_fail    <= 1'b0;
      err_timeout <= 1'b0;
      err_phase   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          st          <= S_LOCK;
          tcnt        <= '0;
          res_pass    <= 1'b0;
          res_fail    <= 1'b0;
          err_timeout <= 1'b0;
          err_phase   <= 1'b0;
        end
        S_LOCK: begin
          if (tcnt != '1) tcnt <= tcnt + 1'b1;
          if (bm_rsp) begin
            if (bm_data == '0) st <= S_PHASE;
            else if (tcnt >= TW'(LOCK_TIMEOUT)) begin
              st          <= S_IDLE;
              done        <= 1'b1;
              err_timeout <= 1'b1;
            end
          end
        end
        S_PHASE: if (bm_rsp) begin
          if (bm_data[8:6] == PH_READY) st <= S_CMD;
          else begin
            st        <= S_IDLE;
            done      <= 1'b1;
            err_phase <= 1'b1;
          end
        end
        S_CMD: if (bm_rsp) st <= S_LEN;
        S_LEN: if (bm_rsp) begin
          st   <= S_DATA;
          pidx <= '0;
        end
        S_DATA: if (bm_rsp) begin
          if (pidx == IW'(PAY_WORDS - 1)) st <= S_EXEC;
          else pidx <= pidx + 1'b1;
        end
        S_EXEC: if (bm_rsp) st <= S_POLL;
        S_POLL: if (bm_rsp && bm_data[3:0] != RC_BUSY) begin
          rc_q <= bm_data[3:0];
          st   <= S_REL;
        end
        S_REL: if (bm_rsp) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          res_fail <= (rc_q == RC_FAIL);
          res_pass <= (rc_q != RC_FAIL);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigv_chk.sv
module sigv_chk
  import sigv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              done,
  input logic              res_pass,
  input logic              res_fail,
  input logic              err_timeout,
  input logic              err_phase
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({res_pass, res_fail, err_timeout, err_phase}) == 1);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_req);

  // R1
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
endmodule

bind sigver_mbox_seq sigv_chk u_chk (.*);

// File: tb/tb_sigver_mbox_seq.sv
module tb_sigver_mbox_seq;
  localparam int TMO = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [383:0] key_x = '0, key_y = '0, sig_r = '0, sig_s = '0;
  logic done, res_pass, res_fail, err_timeout, err_phase;
  logic bus_req, bus_we;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  int checks = 0, fails = 0;
  int lock_left, poll_left, wdelay, wr_n, lock_reads, sts_reads;
  logic [2:0] phase_cfg;
  logic [3:0] res_cfg;
  logic exec_on;
  logic [7:0] wr_addr [64];
  logic [31:0] wr_data [64];

  always #4 clk = ~clk;

  sigver_mbox_seq #(.LOCK_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .key_x(key_x), .key_y(key_y), .sig_r(sig_r), .sig_s(sig_s),
    .done(done), .res_pass(res_pass), .res_fail(res_fail),
    .err_timeout(err_timeout), .err_phase(err_phase),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // behavioural mailbox, acts on the falling edge
  always @(negedge clk) begin
    if (bus_ack) bus_ack = 1'b0;
    else if (rst_n && bus_req) begin
      if (wdelay != 0) wdelay--;
      else begin
        bus_ack = 1'b1;
        wdelay = int'($urandom % 4);
        bus_rdata = '0;
        if (bus_we) begin
          if (wr_n < 64) begin
            wr_addr[wr_n] = bus_addr;
            wr_data[wr_n] = bus_wdata;
          end
          wr_n++;
          if (bus_addr == 8'h18) exec_on = bus_wdata[0];
        end else if (bus_addr == 8'h00) begin
          lock_reads++;
          if (lock_left != 0) begin bus_rdata = 32'd1; lock_left--; end
        end else if (bus_addr == 8'h1C) begin
          sts_reads++;
          if (!exec_on) bus_rdata = 32'(phase_cfg) << 6;
          else if (poll_left != 0) begin bus_rdata = 32'h0000_0180; poll_left--; end
          else bus_rdata = {28'h0, res_cfg};
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_csum(input logic [383:0] x, y, r, s);
    logic [31:0] c = 32'h0;
    c = c - 32'h56 - 32'h47 - 32'h49 - 32'h53;
    for (int i = 0; i < 48; i++) c = c - 32'(x[8*i +: 8]);
    for (int i = 0; i < 48; i++) c = c - 32'(y[8*i +: 8]);
    for (int i = 0; i < 48; i++) c = c - 32'(r[8*i +: 8]);
    for (int i = 0; i < 48; i++) c = c - 32'(s[8*i +: 8]);
    return c;
  endfunction

  function automatic logic [383:0] rnd384();
    logic [383:0] v;
    for (int i = 0; i < 12; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // kind: 0 pass, 1 fail, 2 timeout, 3 phase error
  task automatic run_case(input logic [383:0] x, y, r, s, input int lk,
                          input logic [2:0] ph, input int pl, input logic [3:0] rc,
                          input int kind);
    int n;
    bit seq_ok;
    logic [7:0] ea;
    logic [31:0] ed;
    lock_left = lk; phase_cfg = ph; poll_left = pl; res_cfg = rc;
    wr_n = 0; lock_reads = 0; sts_reads = 0; exec_on = 1'b0;
    @(negedge clk);
    key_x = x; key_y = y; sig_r = r; sig_s = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // R1: scramble operands after capture
    key_x = rnd384(); key_y = rnd384(); sig_r = rnd384(); sig_s = rnd384();
    check(in_ready == 1'b0, "R10", "in_ready after accept", 32'(in_ready), 32'h0);
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R8", "done seen", 32'(done), 32'h1);
    check({res_pass, res_fail, err_timeout, err_phase} ==
          4'(4'b1000 >> kind), "R8", "outcome flags",
          32'({res_pass, res_fail, err_timeout, err_phase}), 32'(4'b1000 >> kind));
    if (kind >= 2) begin
      check(wr_n == 0, kind == 2 ? "R3" : "R4", "writes after error", 32'(wr_n), 32'h0);
      if (kind == 3) check(lock_reads == lk + 1, "R2", "lock reads", 32'(lock_reads), 32'(lk + 1));
    end else begin
      check(lock_reads == lk + 1, "R2", "lock reads", 32'(lock_reads), 32'(lk + 1));
      check(wr_n == 53, "R5", "write count", 32'(wr_n), 32'd53);
      check(wr_n >= 3 && wr_data[2] == exp_csum(x, y, r, s), "R6", "checksum word",
            wr_data[2], exp_csum(x, y, r, s));
      seq_ok = (wr_n == 53);
      for (int i = 0; i < 53 && seq_ok; i++) begin
        if (i == 0) begin ea = 8'h08; ed = 32'h5349_4756; end
        else if (i == 1) begin ea = 8'h0C; ed = 32'd196; end
        else if (i == 2) begin ea = 8'h10; ed = exp_csum(x, y, r, s); end
        else if (i < 51) begin
          ea = 8'h10;
          case ((i - 3) / 12)
            0: ed = x[32*((i-3)%12) +: 32];
            1: ed = y[32*((i-3)%12) +: 32];
            2: ed = r[32*((i-3)%12) +: 32];
            default: ed = s[32*((i-3)%12) +: 32];
          endcase
        end else if (i == 51) begin ea = 8'h18; ed = 32'd1; end
        else begin ea = 8'h18; ed = 32'd0; end
        if (wr_addr[i] != ea || wr_data[i] != ed) begin
          seq_ok = 1'b0;
          $display("  mismatch at write %0d: %h/%h vs %h/%h", i, wr_addr[i], wr_data[i], ea, ed);
        end
      end
      check(seq_ok, "R5 R6 R1", "write order and payload", 32'(wr_n), 32'd53);
      check(sts_reads == pl + 2, "R7", "status reads", 32'(sts_reads), 32'(pl + 2));
    end
    @(negedge clk);
    check(done == 1'b0 && in_ready == 1'b1, "R10", "idle after done",
          32'({done, in_ready}), 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240920));
    wdelay = 0; wr_n = 0; lock_left = 0; poll_left = 0;
    phase_cfg = 3'd1; res_cfg = 4'd2; exec_on = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && done == 1'b0 && bus_req == 1'b0, "R10", "reset state",
          32'({in_ready, done, bus_req}), 32'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(bus_req == 1'b0, "R10", "idle with no request", 32'(bus_req), 32'h0);
    // directed corners
    run_case('0, '0, '0, '0, 0, 3'd1, 0, 4'd2, 0);
    run_case('1, '1, '1, '1, 0, 3'd1, 3, 4'd1, 0);
    run_case(rnd384(), rnd384(), rnd384(), rnd384(), 4, 3'd1, 10, 4'd3, 1);
    run_case(rnd384(), rnd384(), rnd384(), rnd384(), 100000, 3'd1, 0, 4'd2, 2);
    run_case(rnd384(), rnd384(), rnd384(), rnd384(), 2, 3'd0, 0, 4'd2, 3);
    run_case(rnd384(), rnd384(), rnd384(), rnd384(), 0, 3'd4, 0, 4'd2, 3);
    // constrained random
    for (int k = 0; k < 16; k++) begin
      logic [3:0] rc;
      rc = 4'(1 + $urandom % 3);
      run_case(rnd384(), rnd384(), rnd384(), rnd384(), int'($urandom % 6), 3'd1,
               int'($urandom % 8), rc, rc == 4'd3 ? 1 : 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule